// File: doc/BRIEF.md
# Host Mailbox and Doorbell Register Bank

This block is the register face of a host-to-service-processor mailbox. A host reaches it over a simple 64-bit register bus that carries a word offset, a write strobe, a read strobe and data. Eight 64-bit mailbox words sit at the bottom of the map. The lower four carry command words toward the service processor, and the upper four carry response words back. Two doorbells sit above them. Each doorbell can be reached through three aliases: a plain write, a write that ANDs into the current value, and a write that ORs into it.

The inbound doorbell tells a command engine that a message is ready. Any write that leaves its message bit set clears that bit at once and sends a one-cycle pulse to the engine. The outbound doorbell collects response flags, both from host writes and from set-bit requests issued by the engine. It is masked to a fixed set of flag bits, and it drives a level interrupt to the host while any flag is set. Bits are numbered MSB-first: bit 0 is data bit [63].

Top module: `mbox_doorbell_regs`

## Requirements
- R1: A write at offsets 0 to 7 stores the full 64-bit word in that mailbox slot. A read strobe at those offsets returns the slot's value on `bus_rdata` one clock after the strobe, and `bus_rdata` holds that value until the next read.
- R2: A plain write to the inbound doorbell (offset 0x10) whose bit 0 (data bit [63]) is set drives `msg_pulse` high for exactly the one cycle after that write's clock edge. A read at 0x10 always returns zero, because the bit clears itself.
- R3: The inbound OR alias (0x12) pulses `msg_pulse` when the written bit 0 is set. The AND alias (0x11) never pulses, because the stored value is always zero. A write to any inbound alias with bit 0 clear gives no pulse.
- R4: A plain write to the outbound doorbell (offset 0x13) replaces its value with the written data ANDed with the flag mask. A read at 0x13 returns the current value.
- R5: The outbound AND alias (0x14) stores the current value ANDed with the data. The OR alias (0x15) stores the current value ORed with the data. Both results are masked.
- R6: The outbound flag mask keeps bits 0 to 4 and bit 14, which is data 64'hF802_0000_0000_0000. Every other bit reads as zero.
- R7: `host_irq` is high exactly when the outbound doorbell is non-zero. It follows the doorbell on the same clock edge that updates it.
- R8: Reads at any offset other than 0 to 7, 0x10 and 0x13 return zero, and this includes the AND and OR aliases. Writes to unlisted offsets change no register.
- R9: The engine's `eng_set` bits are ORed into the outbound doorbell, after masking, after any bus write in the same cycle. An engine request is therefore never lost.
- R10: A synchronous reset clears all mailbox words, both doorbells, `bus_rdata`, `msg_pulse` and `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| eng_set | input | 64 | Engine set-bit requests for the outbound doorbell |
| msg_pulse | output | 1 | One-cycle message-waiting event to the engine |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
Every result of this block lands on the first clock edge after its stimulus. Read data, the message pulse and the interrupt level all change on that edge. The bench drives each vector on a falling edge and samples on the next falling edge, half a period after the capturing rising edge. That way a single registered stage separates stimulus from check for all three outputs. The pulse and the interrupt are checked on every vector, including read vectors, so a pulse that stays high a second cycle, or an interrupt that lags by a cycle, shows up as a miscompare.

// File: rtl/mbox_doorbell_regs.sv
module mbox_doorbell_regs #(
  parameter int AW     = 6,
  parameter int NWORDS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [63:0]   bus_wdata,
  output logic [63:0]   bus_rdata,
  input  logic [63:0]   eng_set,
  output logic          msg_pulse,
  output logic          host_irq
);
  localparam int          IW       = $clog2(NWORDS);
  localparam logic [63:0] IN_MASK  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OUT_MASK = 64'hF802_0000_0000_0000;
  localparam logic [AW-1:0] IN_RW   = AW'(6'h10);
  localparam logic [AW-1:0] IN_AND  = AW'(6'h11);
  localparam logic [AW-1:0] IN_OR   = AW'(6'h12);
  localparam logic [AW-1:0] OUT_RW  = AW'(6'h13);
  localparam logic [AW-1:0] OUT_AND = AW'(6'h14);
  localparam logic [AW-1:0] OUT_OR  = AW'(6'h15);

  logic [63:0] mbox [NWORDS];
  logic [63:0] in_db, out_db;
  logic [63:0] in_val, out_val;
  logic        in_hit, out_hit, in_fire, mbox_sel;

  assign mbox_sel = bus_addr < AW'(NWORDS);

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                  mbox[i] <= '0;
      else if (bus_wr && bus_addr == AW'(i))    mbox[i] <= bus_wdata;
    end
  end

  always_comb begin
    in_hit = 1'b1;
    unique case (bus_addr)
      IN_RW:   in_val = bus_wdata;
      IN_AND:  in_val = in_db & bus_wdata;
      IN_OR:   in_val = in_db | bus_wdata;
      default: begin in_val = in_db; in_hit = 1'b0; end
    endcase
    in_val  = in_val & IN_MASK;
    in_hit  = in_hit && bus_wr;
    in_fire = in_hit && in_val[63];
  end

  always_comb begin
    out_hit = 1'b1;
    unique case (bus_addr)
      OUT_RW:  out_val = bus_wdata;
      OUT_AND: out_val = out_db & bus_wdata;
      OUT_OR:  out_val = out_db | bus_wdata;
      default: begin out_val = out_db; out_hit = 1'b0; end
    endcase
    out_val = ((bus_wr && out_hit) ? out_val : out_db) | eng_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_db     <= '0;
      out_db    <= '0;
      msg_pulse <= 1'b0;
    end else begin
      in_db     <= in_fire ? '0 : (in_hit ? in_val : in_db);
      out_db    <= out_val & OUT_MASK;
      msg_pulse <= in_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              bus_rdata <= '0;
    else if (bus_rd) begin
      if (mbox_sel)                 bus_rdata <= mbox[bus_addr[IW-1:0]];
      else if (bus_addr == IN_RW)   bus_rdata <= in_db;
      else if (bus_addr == OUT_RW)  bus_rdata <= out_db;
      else                          bus_rdata <= '0;
    end
  end

  assign host_irq = |out_db;

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    msg_pulse |-> $past(bus_wr && bus_wdata[63] &&
                        (bus_addr == IN_RW || bus_addr == IN_OR))); // R2
  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == OUT_RW |=> (bus_rdata & ~OUT_MASK) == '0); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !mbox_sel && bus_addr != IN_RW && bus_addr != OUT_RW
    |=> bus_rdata == '0); // R8
  AST_ENG_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|(eng_set & OUT_MASK)) |=> host_irq); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!host_irq && !msg_pulse && bus_rdata == '0)); // R10
endmodule

// File: tb/test_mbox_doorbell_regs.sv
module test_mbox_doorbell_regs;
  localparam int CLK_P = 10;
  localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] B = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] M = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic        wr, rd;
    logic [5:0]  adr;
    logic [63:0] dat, eng, exp_rd;
    logic        exp_irq, exp_pls;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1,0,6'h00,A,0,0,0,0,"R1 "},
    '{1,0,6'h07,B,0,0,0,0,"R1 "},
    '{0,1,6'h00,0,0,A,0,0,"R1 "},
    '{0,1,6'h07,0,0,B,0,0,"R1 "},
    '{0,1,6'h03,0,0,0,0,0,"R1 "},
    '{1,0,6'h10,M,0,0,0,1,"R2 "},
    '{0,1,6'h10,0,0,0,0,0,"R2 "},
    '{1,0,6'h10,~M,0,0,0,0,"R3 "},
    '{1,0,6'h12,M,0,0,0,1,"R3 "},
    '{1,0,6'h11,F,0,0,0,0,"R3 "},
    '{1,0,6'h13,F,0,0,1,0,"R4 "},
    '{0,1,6'h13,0,0,64'hF802_0000_0000_0000,1,0,"R6 "},
    '{1,0,6'h14,M,0,0,1,0,"R5 "},
    '{0,1,6'h13,0,0,M,1,0,"R5 "},
    '{1,0,6'h15,64'h0002_0000_0000_0001,0,0,1,0,"R5 "},
    '{0,1,6'h13,0,0,64'h8002_0000_0000_0000,1,0,"R6 "},
    '{0,1,6'h14,0,0,0,1,0,"R8 "},
    '{0,1,6'h15,0,0,0,1,0,"R8 "},
    '{0,1,6'h11,0,0,0,1,0,"R8 "},
    '{1,0,6'h13,0,0,0,0,0,"R7 "},
    '{1,0,6'h08,F,0,0,0,0,"R8 "},
    '{0,1,6'h08,0,0,0,0,0,"R8 "},
    '{0,1,6'h00,0,0,A,0,0,"R8 "},
    '{1,0,6'h13,0,64'h4000_0000_0000_0000,0,1,0,"R9 "},
    '{0,1,6'h13,0,0,64'h4000_0000_0000_0000,1,0,"R9 "},
    '{0,0,6'h00,0,F,0,1,0,"R9 "},
    '{0,1,6'h13,0,0,64'hF802_0000_0000_0000,1,0,"R9 "},
    '{1,0,6'h13,0,0,0,0,0,"R7 "}
  };

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0, eng_set = '0, bus_rdata;
  logic msg_pulse, host_irq;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mbox_doorbell_regs i_mbox_doorbell_regs (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .eng_set, .msg_pulse, .host_irq);

  task automatic check(input logic [63:0] act, exp, input logic [23:0] tag,
                       input string what);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, rd, input logic [5:0] adr,
                       input logic [63:0] dat, eng);
    bus_wr = wr; bus_rd = rd; bus_addr = adr; bus_wdata = dat; eng_set = eng;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_set = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(bus_rdata, 0, "R10", "rdata after reset");
    check(64'(host_irq), 0, "R10", "irq after reset");
    check(64'(msg_pulse), 0, "R10", "pulse after reset");
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].wr, VEC[k].rd, VEC[k].adr, VEC[k].dat, VEC[k].eng);
      if (VEC[k].rd) check(bus_rdata, VEC[k].exp_rd, VEC[k].tag, $sformatf("rdata v%0d", k));
      check(64'(host_irq), 64'(VEC[k].exp_irq), VEC[k].tag, $sformatf("irq v%0d", k));
      check(64'(msg_pulse), 64'(VEC[k].exp_pls), VEC[k].tag, $sformatf("pulse v%0d", k));
    end
    // R2: back-to-back rings give one pulse each, then quiet
    drive(1, 0, 6'h10, M, 0);
    check(64'(msg_pulse), 1, "R2 ", "first ring");
    drive(1, 0, 6'h12, F, 0);
    check(64'(msg_pulse), 1, "R3 ", "second ring");
    drive(0, 0, 6'h00, 0, 0);
    check(64'(msg_pulse), 0, "R2 ", "pulse drop");
    // R10: mid-run reset clears mailbox and outbound doorbell
    drive(1, 0, 6'h05, B, 0);
    drive(1, 0, 6'h15, M, 0);
    check(64'(host_irq), 1, "R10", "irq before reset");
    rst = 1; @(negedge clk); rst = 0;
    check(64'(host_irq), 0, "R10", "irq after mid reset");
    drive(0, 1, 6'h05, 0, 0);
    check(bus_rdata, 0, "R10", "mailbox after mid reset");
    drive(0, 1, 6'h13, 0, 0);
    check(bus_rdata, 0, "R10", "doorbell after mid reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule